// File: doc/BRIEF.md
# Addressable Bit Latch with Demultiplexer Mode

This block stores eight bits that share one data input. A 3-bit address picks one of the eight bits. Two active-low controls, `en_n` and `clr_n`, choose one of four behaviours. In write mode the chosen bit takes the data value. In hold mode nothing changes. In demultiplexer mode the data value goes to the chosen output and all other outputs go low. In clear mode every output goes low.

All of this is synchronous. The controls, address and data are sampled on the rising clock edge, and the eight outputs come straight from flops. The value on the outputs is also the stored state. A design that uses demultiplexer or clear mode and then returns to hold mode keeps whatever those modes left on the outputs.

A separate synchronous, active-high `rst` clears the storage at start-up. An address should only change while the block is in hold mode. In this clocked form a change takes effect at the next edge, so it cannot briefly select the wrong bit.

Top module: `bit_addr_latch`

## Requirements
- R1: While `rst` is high at a rising edge, every bit of `q` is 0 after that edge.
- R2: With `en_n`=0 and `clr_n`=1, a rising edge copies `din` into bit `q[addr]`, and every other bit keeps its value.
- R3: With `en_n`=1 and `clr_n`=1, a rising edge leaves `q` unchanged, whatever `addr` and `din` are.
- R4: With `en_n`=0 and `clr_n`=0, a rising edge sets `q[addr]` to `din` and every other bit to 0.
- R5: With `en_n`=1 and `clr_n`=0, a rising edge sets every bit of `q` to 0, whatever `addr` and `din` are.
- R6: The address is an unsigned binary number, with `addr[2]` the most significant bit. A value k selects bit k of `q`, so 0 selects `q[0]` and 7 selects `q[7]`.
- R7: After demultiplexer or clear mode, hold mode keeps the values those modes left on `q`.
- R8: Every change to `q` appears one clock after the edge at which its inputs were sampled, and at no other time.
- R9: `rst` takes priority over `en_n`, `clr_n`, `addr` and `din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears all bits |
| en_n | input | 1 | Enable control, active low |
| clr_n | input | 1 | Clear control, active low |
| addr | input | 3 | Bit select, binary |
| din | input | 1 | Data value for the selected bit |
| q | output | 8 | Registered stored bits |

## Verification
Two functions can act in the same cycle.

- **System reset and a functional mode.** The bench raises `rst` while write mode is active with `din`=1. The expected result is that `q` is all zeros, which shows that reset wins.
- **A demultiplexer write and the clearing of the stored bits.** In demultiplexer mode one bit is written while the other seven are cleared in the same edge. The bench first fills `q` with ones and then applies demultiplexer mode. It judges the result by checking that exactly the addressed bit survives, then enters hold mode to confirm that this pattern is kept.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_CLEAR = 2'd3
  } latch_mode_e;
endpackage

// File: rtl/al_mode_dec.sv
module al_mode_dec
  import addr_latch_pkg::*;
(
  input  logic        en_n,
  input  logic        clr_n,
  output latch_mode_e mode
);
  always_comb begin
    unique case ({en_n, clr_n})
      2'b01:   mode = MODE_WRITE;
      2'b11:   mode = MODE_HOLD;
      2'b00:   mode = MODE_DEMUX;
      default: mode = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/al_addr_dec.sv
module al_addr_dec #(
  parameter int ADDR_W = 3,
  localparam int N_OUT = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_OUT-1:0]  sel
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_sel
    assign sel[k] = (addr == ADDR_W'(k));
  end
endmodule

// File: rtl/al_bit_cell.sv
module al_bit_cell
  import addr_latch_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  latch_mode_e mode,
  input  logic        sel,
  input  logic        din,
  output logic        q
);
  logic q_next;

  always_comb begin
    q_next = q;
    unique case (mode)
      MODE_WRITE: if (sel) q_next = din;
      MODE_HOLD:  q_next = q;
      MODE_DEMUX: q_next = sel & din;
      MODE_CLEAR: q_next = 1'b0;
      default:    q_next = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_next;
  end
endmodule

// File: rtl/bit_addr_latch.sv
module bit_addr_latch
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int N_OUT = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_n,
  input  logic              clr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic [N_OUT-1:0]  q
);
  latch_mode_e       mode;
  logic [N_OUT-1:0]  sel;

  al_mode_dec u_mode (.en_n(en_n), .clr_n(clr_n), .mode(mode));

  al_addr_dec #(.ADDR_W(ADDR_W)) u_adec (.addr(addr), .sel(sel));

  for (genvar k = 0; k < N_OUT; k++) begin : g_cell
    al_bit_cell u_cell (
      .clk(clk), .rst(rst), .mode(mode),
      .sel(sel[k]), .din(din), .q(q[k])
    );
  end

  // R1 R9
  sys_reset_clears_chk: assert property (@(posedge clk) rst |=> q == '0);

  // R2
  write_keeps_others_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_n && clr_n) |=> ((q ^ $past(q)) & ~(N_OUT'(1) << $past(addr))) == '0);

  // R6
  write_lands_addressed_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_n && clr_n) |=> q[$past(addr)] == $past(din));

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (en_n && clr_n) |=> $stable(q));

  // R4
  demux_single_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_n && !clr_n) |=> ($onehot0(q) && q[$past(addr)] == $past(din)));

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (en_n && !clr_n) |=> q == '0);
endmodule

// File: tb/bit_addr_latch_tb.sv
`timescale 1ns/1ps
module bit_addr_latch_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_n = 1'b1;
  logic       clr_n = 1'b1;
  logic [2:0] addr = '0;
  logic       din = 1'b0;
  logic [7:0] q;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 0;
  logic [7:0] model = '0;
  logic [7:0] exp_q[$];
  string      exp_tag[$];

  always #2 clk = ~clk;

  bit_addr_latch u_dut (
    .clk(clk), .rst(rst), .en_n(en_n), .clr_n(clr_n),
    .addr(addr), .din(din), .q(q)
  );

  // driver: applies one cycle of stimulus and predicts the result
  task automatic step(input logic r, input logic e, input logic c,
                      input logic [2:0] a, input logic d, input string tag);
    @(negedge clk);
    rst = r; en_n = e; clr_n = c; addr = a; din = d;
    if (r)                 model = '0;
    else if (!e && c)      model[a] = d;
    else if (!e && !c)     model = 8'(d) << a;
    else if (e && !c)      model = '0;
    exp_q.push_back(model);
    exp_tag.push_back(tag);
  endtask

  // monitor: compares one cycle after each driven edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        n_checks++;
        if (q !== e) begin
          n_errors++;
          $display("FAIL %s: q=%02h expected=%02h", t, q, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: timeout actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    step(1, 1, 1, 0, 0, "R1");
    step(1, 0, 1, 5, 1, "R1");
    for (int k = 0; k < 8; k++) step(0, 0, 1, 3'(k), 1, "R2 R6 fill");
    for (int k = 0; k < 8; k++) step(0, 1, 1, 3'(7 - k), k[0], "R3 hold ignores addr/din");
    step(0, 0, 1, 3, 0, "R2 clear bit3");
    step(0, 0, 1, 6, 0, "R2 clear bit6");
    step(0, 0, 1, 3, 1, "R2 set bit3");
    for (int k = 0; k < 8; k++) step(0, 0, 0, 3'(k), 1, "R4 R6 demux d=1");
    step(0, 1, 1, 2, 0, "R7 hold after demux");
    step(0, 1, 1, 4, 1, "R7 hold after demux");
    step(0, 0, 0, 5, 0, "R4 demux d=0");
    for (int k = 0; k < 8; k++) step(0, 0, 1, 3'(k), 1, "R2 refill");
    step(0, 0, 0, 6, 1, "R4 demux drops others");
    step(0, 1, 1, 0, 0, "R7 hold demux pattern");
    for (int k = 0; k < 8; k++) step(0, 0, 1, 3'(k), 1, "R2 refill");
    step(0, 1, 0, 4, 1, "R5 clear");
    step(0, 1, 1, 1, 1, "R7 hold after clear");
    step(0, 0, 1, 7, 1, "R2 set bit7");
    step(1, 0, 1, 2, 1, "R9 rst over write");
    step(0, 0, 1, 1, 1, "R2 after rst");
    // R8: mixed stream, each result expected exactly one edge later
    lfsr = 8'hA5;
    for (int k = 0; k < 80; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step((lfsr[7:5] == 3'b111), lfsr[0], lfsr[1] | lfsr[6], lfsr[4:2], lfsr[5], "R8 mixed");
    end
    step(0, 1, 1, 0, 0, "R3 final hold");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule